// File: doc/BRIEF.md
# Batched Training Pipeline Scheduler

This block sequences images through a layer-pipelined training engine with a configurable number of layers. The pipeline has one forward stage per layer, a single error stage where the output is compared with the label, and one backward stage per layer. Each cycle the scheduler either issues a new image into the first forward stage or inserts a bubble. Every occupied stage carries a valid flag and the tag of its image. The datapath and the memories sit outside the block and follow these flags.

Weights stay fixed for a whole batch. After the image that fills the batch has been issued, the scheduler refuses new images until the pipeline is empty. The gap after that last image is twice the layer count plus one cycles. The scheduler then raises a single-cycle weight-update strobe, clears its batch count, and accepts images again from the next cycle. The datapath averages the gradients over the batch. The scheduler also produces, for each layer, the write enable and the read enable for the buffer that keeps that layer's forward result until the backward pass needs it.

Top module: `train_pipe_sched`

## Requirements
- R1: While reset is held and in the first cycle after it, no stage is valid, the update strobe is low and the batch fill count is 0.
- R2: When issue is allowed, `img_issue_o` equals `img_avail_i` in the same cycle. An issued image is valid in stage 0 in the next cycle, carrying the `issue_tag_o` value it was issued with. Tags start at 0 and increase by one per issued image, modulo 2^TAG_W.
- R3: Stages are numbered 0 to 2L. Stages 0..L-1 are forward, stage L is the error stage and stages L+1..2L are backward. In each cycle, stage i+1 takes the valid flag and the tag that stage i held in the previous cycle.
- R4: A cycle without an available image is a bubble. Stage 0 is invalid in the next cycle, the batch fill count is unchanged and no tag is consumed.
- R5: After the issue that brings the fill count to BATCH, `img_issue_o` stays low for the next 2L+2 cycles, whatever `img_avail_i` does.
- R6: Let the last image of a batch be issued in cycle t. Then `wupd_o` is high in cycle t+2L+2 only, for exactly one cycle, and in that cycle every stage is invalid.
- R7: `batch_fill_o` counts the images issued in the current batch. It shows BATCH from the last issue up to and including the strobe cycle, and 0 in the cycle after the strobe. Issue may resume in that same cycle.
- R8: For layer k (1..L), bit k-1 of `buf_wr_o` is high exactly when forward stage index k-1 holds a valid image.
- R9: For layer k, bit k-1 of `buf_rd_o` is high exactly when stage index 2L-k+1 holds a valid image. The number of entries outstanding per layer never exceeds 2(L-k)+2, and no read happens with none outstanding.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| img_avail_i | input | 1 | A new image is ready to enter |
| img_issue_o | output | 1 | The image is taken this cycle |
| issue_tag_o | output | TAG_W | Tag given to an image issued this cycle |
| stage_valid_o | output | 2L+1 | Valid flag per stage, bit i = stage i |
| stage_tag_o | output | (2L+1)*TAG_W | Tag per stage, stage i in bits i*TAG_W upward |
| buf_wr_o | output | L | Per-layer intermediate buffer write enable |
| buf_rd_o | output | L | Per-layer intermediate buffer read enable |
| wupd_o | output | 1 | One-cycle weight-update strobe |
| batch_fill_o | output | clog2(BATCH+1) | Images issued in the current batch |

## Verification
The assertions assume that reset is asserted from time zero for at least one clock edge. They also assume that `img_avail_i` is a clean level that does not depend on `img_issue_o` within the same cycle. Apart from that they accept any availability pattern. The availability input is held low during reset, because issue is not gated by reset. The stimulus drives availability only on the falling edge. It mixes long runs of constant availability, long bubble runs and random densities, so that images keep offering themselves during drains and batches end on every phase of the tag counter.

// File: rtl/tps_pkg.sv
package tps_pkg;

  typedef enum logic [1:0] {
    PH_ISSUE  = 2'd0,
    PH_DRAIN  = 2'd1,
    PH_UPDATE = 2'd2
  } phase_e;

  // total stages: forward, error, backward
  function automatic int unsigned stage_count(input int unsigned layers);
    return 2 * layers + 1;
  endfunction

  // cycles between the batch-closing issue and the update strobe
  function automatic int unsigned drain_len(input int unsigned layers);
    return 2 * layers + 1;
  endfunction

  // stage index whose departure writes the buffer of layer k (1-based)
  function automatic int unsigned wr_stage(input int unsigned k);
    return k - 1;
  endfunction

  // stage index whose arrival reads the buffer of layer k (1-based)
  function automatic int unsigned rd_stage(input int unsigned layers, input int unsigned k);
    return 2 * layers - k + 1;
  endfunction

  // entries layer k must be able to hold
  function automatic int unsigned buf_slots(input int unsigned layers, input int unsigned k);
    return 2 * (layers - k) + 2;
  endfunction

endpackage

// File: rtl/tps_batch_ctrl.sv
module tps_batch_ctrl
  import tps_pkg::*;
#(
  parameter int unsigned NUM_LAYERS = 3,
  parameter int unsigned BATCH      = 4,
  parameter int unsigned CNT_W      = $clog2(BATCH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             avail_i,
  output logic             issue_o,
  output logic             upd_o,
  output logic [CNT_W-1:0] fill_o
);

  localparam int unsigned DRAIN_LEN = drain_len(NUM_LAYERS);
  localparam int unsigned DRN_W     = $clog2(DRAIN_LEN + 1);

  phase_e             phase_q;
  logic [CNT_W-1:0]   cnt_q;
  logic [DRN_W-1:0]   drn_q;
  logic               closing_issue;

  assign issue_o       = (phase_q == PH_ISSUE) && avail_i;
  assign closing_issue = issue_o && (cnt_q == CNT_W'(BATCH - 1));
  assign upd_o         = (phase_q == PH_UPDATE);
  assign fill_o        = cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase_q <= PH_ISSUE;
      cnt_q   <= '0;
      drn_q   <= '0;
    end else begin
      unique case (phase_q)
        PH_ISSUE: begin
          if (issue_o) cnt_q <= cnt_q + 1'b1;
          if (closing_issue) begin
            phase_q <= PH_DRAIN;
            drn_q   <= '0;
          end
        end
        PH_DRAIN: begin
          if (drn_q == DRN_W'(DRAIN_LEN - 1)) phase_q <= PH_UPDATE;
          else                                drn_q   <= drn_q + 1'b1;
        end
        PH_UPDATE: begin
          phase_q <= PH_ISSUE;
          cnt_q   <= '0;
        end
        default: phase_q <= PH_ISSUE;
      endcase
    end
  end

  // R6
  upd_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    upd_o |=> !upd_o);

  // R7
  fill_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    upd_o |=> (fill_o == '0));

  // R7
  fill_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fill_o <= CNT_W'(BATCH));

  // R4
  bubble_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!issue_o && !upd_o) |=> $stable(fill_o));

endmodule

// File: rtl/tps_stage_shift.sv
module tps_stage_shift #(
  parameter int unsigned DEPTH = 7,
  parameter int unsigned TAG_W = 6
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   in_valid,
  input  logic [TAG_W-1:0]       in_tag,
  output logic [DEPTH-1:0]       valid_o,
  output logic [DEPTH*TAG_W-1:0] tag_flat_o
);

  logic [DEPTH-1:0]            valid_q;
  logic [DEPTH-1:0][TAG_W-1:0] tag_q;

  for (genvar i = 0; i < DEPTH; i++) begin : g_stage
    if (i == 0) begin : g_head
      always_ff @(posedge clk) begin
        if (!rst_n) begin
          valid_q[i] <= 1'b0;
          tag_q[i]   <= '0;
        end else begin
          valid_q[i] <= in_valid;
          tag_q[i]   <= in_tag;
        end
      end
    end else begin : g_body
      always_ff @(posedge clk) begin
        if (!rst_n) begin
          valid_q[i] <= 1'b0;
          tag_q[i]   <= '0;
        end else begin
          valid_q[i] <= valid_q[i-1];
          tag_q[i]   <= tag_q[i-1];
        end
      end

      // R3
      advance_chk: assert property (@(posedge clk) disable iff (!rst_n)
        valid_q[i-1] |=> (valid_q[i] && (tag_q[i] == $past(tag_q[i-1]))));
    end
  end

  assign valid_o    = valid_q;
  assign tag_flat_o = tag_q;

endmodule

// File: rtl/tps_buf_enables.sv
module tps_buf_enables
  import tps_pkg::*;
#(
  parameter int unsigned NUM_LAYERS = 3,
  parameter int unsigned DEPTH      = 7
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [DEPTH-1:0]      stage_valid_i,
  output logic [NUM_LAYERS-1:0] wr_o,
  output logic [NUM_LAYERS-1:0] rd_o
);

  localparam int unsigned OCC_W = $clog2(2 * NUM_LAYERS + 3);

  for (genvar k = 1; k <= NUM_LAYERS; k++) begin : g_layer
    localparam int unsigned WS    = wr_stage(k);
    localparam int unsigned RS    = rd_stage(NUM_LAYERS, k);
    localparam int unsigned SLOTS = buf_slots(NUM_LAYERS, k);

    logic [OCC_W-1:0] occ_q;

    assign wr_o[k-1] = stage_valid_i[WS];
    assign rd_o[k-1] = stage_valid_i[RS];

    // outstanding entries, kept for the checks below
    always_ff @(posedge clk) begin
      if (!rst_n) occ_q <= '0;
      else        occ_q <= occ_q + OCC_W'(wr_o[k-1]) - OCC_W'(rd_o[k-1]);
    end

    // R9
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      occ_q <= OCC_W'(SLOTS));

    // R9
    no_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rd_o[k-1] |-> (occ_q != '0));
  end

endmodule

// File: rtl/train_pipe_sched.sv
module train_pipe_sched
  import tps_pkg::*;
#(
  parameter int unsigned NUM_LAYERS = 3,
  parameter int unsigned BATCH      = 4,
  parameter int unsigned TAG_W      = 6,
  localparam int unsigned DEPTH     = stage_count(NUM_LAYERS),
  localparam int unsigned CNT_W     = $clog2(BATCH + 1)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   img_avail_i,
  output logic                   img_issue_o,
  output logic [TAG_W-1:0]       issue_tag_o,
  output logic [DEPTH-1:0]       stage_valid_o,
  output logic [DEPTH*TAG_W-1:0] stage_tag_o,
  output logic [NUM_LAYERS-1:0]  buf_wr_o,
  output logic [NUM_LAYERS-1:0]  buf_rd_o,
  output logic                   wupd_o,
  output logic [CNT_W-1:0]       batch_fill_o
);

  localparam int unsigned GAP   = drain_len(NUM_LAYERS) + 1;
  localparam int unsigned SNC_W = $clog2(GAP + 1);

  logic [TAG_W-1:0] tag_ctr_q;
  logic             issue_w;

  tps_batch_ctrl #(
    .NUM_LAYERS (NUM_LAYERS),
    .BATCH      (BATCH),
    .CNT_W      (CNT_W)
  ) u_ctrl (
    .clk     (clk),
    .rst_n   (rst_n),
    .avail_i (img_avail_i),
    .issue_o (issue_w),
    .upd_o   (wupd_o),
    .fill_o  (batch_fill_o)
  );

  always_ff @(posedge clk) begin
    if (!rst_n)       tag_ctr_q <= '0;
    else if (issue_w) tag_ctr_q <= tag_ctr_q + 1'b1;
  end

  tps_stage_shift #(
    .DEPTH (DEPTH),
    .TAG_W (TAG_W)
  ) u_shift (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_valid   (issue_w),
    .in_tag     (tag_ctr_q),
    .valid_o    (stage_valid_o),
    .tag_flat_o (stage_tag_o)
  );

  tps_buf_enables #(
    .NUM_LAYERS (NUM_LAYERS),
    .DEPTH      (DEPTH)
  ) u_bufen (
    .clk           (clk),
    .rst_n         (rst_n),
    .stage_valid_i (stage_valid_o),
    .wr_o          (buf_wr_o),
    .rd_o          (buf_rd_o)
  );

  assign img_issue_o = issue_w;
  assign issue_tag_o = tag_ctr_q;

  // cycles since the batch-closing issue, 0 when none pending
  logic [SNC_W-1:0] since_q;
  logic             close_w;
  assign close_w = issue_w && (batch_fill_o == CNT_W'(BATCH - 1));

  always_ff @(posedge clk) begin
    if (!rst_n)                         since_q <= '0;
    else if (close_w)                   since_q <= SNC_W'(1);
    else if (since_q == SNC_W'(GAP))    since_q <= '0;
    else if (since_q != '0)             since_q <= since_q + 1'b1;
  end

  // R6
  upd_when_due_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wupd_o == (since_q == SNC_W'(GAP)));

  // R6
  upd_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wupd_o |-> (stage_valid_o == '0));

  // R5
  drain_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (since_q != '0) |-> !img_issue_o);

  // R2
  issue_enters_chk: assert property (@(posedge clk) disable iff (!rst_n)
    img_issue_o |=> (stage_valid_o[0] && (stage_tag_o[TAG_W-1:0] == $past(issue_tag_o))));

  // R4
  bubble_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !img_issue_o |=> (!stage_valid_o[0] && $stable(issue_tag_o)));

endmodule

// File: tb/train_pipe_sched_bench.sv
`timescale 1ns/1ps
module train_pipe_sched_bench;

  localparam int L     = 3;
  localparam int BATCH = 4;
  localparam int TAG_W = 6;
  localparam int DEPTH = 2 * L + 1;
  localparam int CNT_W = $clog2(BATCH + 1);

  logic                   clk = 1'b0;
  logic                   rst_n = 1'b0;
  logic                   img_avail = 1'b0;
  logic                   img_issue;
  logic [TAG_W-1:0]       issue_tag;
  logic [DEPTH-1:0]       stage_valid;
  logic [DEPTH*TAG_W-1:0] stage_tag;
  logic [L-1:0]           buf_wr;
  logic [L-1:0]           buf_rd;
  logic                   wupd;
  logic [CNT_W-1:0]       batch_fill;

  int checks   = 0;
  int failures = 0;
  int strobes  = 0;
  bit done     = 1'b0;

  always #10 clk = ~clk;

  train_pipe_sched #(.NUM_LAYERS(L), .BATCH(BATCH), .TAG_W(TAG_W)) u_train_pipe_sched (
    .clk           (clk),
    .rst_n         (rst_n),
    .img_avail_i   (img_avail),
    .img_issue_o   (img_issue),
    .issue_tag_o   (issue_tag),
    .stage_valid_o (stage_valid),
    .stage_tag_o   (stage_tag),
    .buf_wr_o      (buf_wr),
    .buf_rd_o      (buf_rd),
    .wupd_o        (wupd),
    .batch_fill_o  (batch_fill)
  );

  // bench model state
  bit m_val [DEPTH];
  int m_tag [DEPTH];
  int m_tagctr = 0;
  int m_fill   = 0;
  int m_blk    = 0;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s act=%0d exp=%0d", req, act, exp);
    end
  endtask

  // layer k (1-based) reads when its image sits in backward stage L-k+1
  function automatic int read_index(input int k);
    return L + (L - k + 1);
  endfunction

  task automatic model_reset();
    for (int i = 0; i < DEPTH; i++) begin
      m_val[i] = 1'b0;
      m_tag[i] = 0;
    end
    m_tagctr = 0;
    m_fill   = 0;
    m_blk    = 0;
  endtask

  // one cycle: drive at the falling edge, compare, advance the model
  task automatic step(input bit avail);
    bit exp_issue;
    @(negedge clk);
    img_avail = avail;
    #1;
    exp_issue = (m_blk == 0) && avail;
    chk(exp_issue ? "R2 issue" : (m_blk != 0 ? "R5 blocked" : "R4 bubble"),
        32'(img_issue), 32'(exp_issue));
    chk("R2 tag", 32'(issue_tag), 32'(m_tagctr));
    chk("R7 fill", 32'(batch_fill), 32'(m_fill));
    chk("R6 strobe", 32'(wupd), 32'(m_blk == 1));
    if (wupd) strobes++;
    for (int i = 0; i < DEPTH; i++) begin
      chk("R3 valid", 32'(stage_valid[i]), 32'(m_val[i]));
      if (m_val[i]) chk("R3 tag", 32'(stage_tag[i*TAG_W +: TAG_W]), 32'(m_tag[i]));
    end
    for (int k = 1; k <= L; k++) begin
      chk("R8 write", 32'(buf_wr[k-1]), 32'(m_val[k-1]));
      chk("R9 read", 32'(buf_rd[k-1]), 32'(m_val[read_index(k)]));
    end
    for (int i = DEPTH - 1; i > 0; i--) begin
      m_val[i] = m_val[i-1];
      m_tag[i] = m_tag[i-1];
    end
    m_val[0] = exp_issue;
    m_tag[0] = m_tagctr;
    if (exp_issue) begin
      m_tagctr = (m_tagctr + 1) % (1 << TAG_W);
      m_fill++;
      if (m_fill == BATCH) m_blk = 2 * L + 2;
    end else if (m_blk > 0) begin
      if (m_blk == 1) m_fill = 0;
      m_blk--;
    end
  endtask

  initial begin
    model_reset();
    void'($urandom(32'd20171));
    rst_n = 1'b0;
    img_avail = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1 during reset
    chk("R1 valid", 32'(stage_valid), 32'd0);
    chk("R1 strobe", 32'(wupd), 32'd0);
    chk("R1 fill", 32'(batch_fill), 32'd0);
    rst_n = 1'b1;
    // R1 first cycle after reset
    step(1'b0);
    chk("R1 empty after", 32'(stage_valid), 32'd0);

    // back-to-back availability across several batches and drains (R5 R6 R7)
    for (int c = 0; c < 45; c++) step(1'b1);
    // bubble run (R4)
    for (int c = 0; c < 15; c++) step(1'b0);
    // single isolated images
    for (int c = 0; c < 30; c++) step(c % 5 == 0);
    // random densities
    for (int blk = 0; blk < 8; blk++) begin
      int unsigned dens = $urandom_range(1, 9);
      for (int c = 0; c < 80; c++) step($urandom_range(0, 9) < dens);
    end
    // let the pipeline drain completely
    for (int c = 0; c < 20; c++) step(1'b0);
    chk("R6 strobes seen", 32'(strobes > 10), 32'd1);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog act=0 exp=1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule